// File: doc/BRIEF.md
# Chirp Pulse Rate Detector

This block decides whether chirped radar pulses are arriving closely enough together to count as a detection. Each time the upstream pulse classifier raises its event strobe, the block takes the current value of a free-running 32-bit tick count. It subtracts the tick value it kept from the event before. Only the difference matters: a short gap adds one to a running count, and a long gap starts the count again at one.

A hit flag is raised for one cycle, in the clock cycle after the strobe, when the running count after that event is above eight. The tick count can come from a port shared with other logic, or from a counter inside the block. A parameter of the top module selects between the two.

Top module: `chirp_rate_detector`

## Requirements
- R1: The elapsed time of an event is the current tick value minus the stored tick value, taken modulo 2^32. A stored value of 0xFFFFFF00 and a current value of 0x00000100 give 0x200.
- R2: When the elapsed time is at most GAP_LIMIT ticks, the running count goes up by one. The default GAP_LIMIT is 12582912, which is 12 × 2^20, and an elapsed time equal to GAP_LIMIT counts as short.
- R3: When an event has a short gap, hit_o is 1 exactly when the running count after that event is greater than HIT_ABOVE. The default HIT_ABOVE is 8, so the ninth close event in a row is the first to give a hit.
- R4: When the elapsed time is greater than GAP_LIMIT, the running count is set to 1 and hit_o stays 0 for that event.
- R5: The running count stops at its largest value (15 with the default 4-bit width) and never wraps. A long run of close events therefore gives a hit on every event.
- R6: Reset (rst_n low at a clock edge) clears the running count, the stored tick value and hit_o. The first event after reset is measured against a stored tick value of zero.
- R7: hit_o is a single-cycle pulse. It is registered at the clock edge that samples evt_i high, and it is 0 in any cycle that does not follow an event.
- R8: Every event replaces the stored tick value with its own tick value, whether or not the event gives a hit.
- R9: While evt_i is low, the running count and the stored tick value keep their values, whatever ts_ext_i does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| evt_i | input | 1 | Strobe: one chirp pulse has been classified |
| ts_ext_i | input | 32 | Free-running tick value, used when TS_SRC is TS_EXTERNAL |
| hit_o | output | 1 | Pulse-rate detection, one cycle |

## Verification
Two things can fall on the same event: a restart after a long gap, and a running count that is sitting at its saturated maximum. The bench first feeds a run of one-tick gaps until the count has been at its ceiling for several events. It then sends one gap of GAP_LIMIT + 1. On that event the bench expects hit_o to be low. It also expects the next close event to leave hit_o low, because the count must have restarted at 1 rather than stayed at 15. Finally it expects a hit again only on the eighth close event after the restart.

// File: rtl/chirp_rate_pkg.sv
// Package: shared definitions for the chirp pulse rate detector.
// Assumes: nothing beyond IEEE 1800-2017 elaboration.
package chirp_rate_pkg;

    // Where the tick count comes from.
    typedef enum logic {
        TS_EXTERNAL = 1'b0,
        TS_INTERNAL = 1'b1
    } ts_src_e;

    // Default gap limit in ticks: 12 * 2^20.
    localparam int unsigned GAP_LIMIT_DEF = 12 * (1 << 20);

endpackage

// File: rtl/crd_ts_source.sv
// Module: crd_ts_source
// Supplies the free-running tick value: either it passes ts_ext_i through,
// or it runs its own counter that wraps modulo 2^TS_W.
// Assumes: in external mode the upstream counter is free-running in clk.
module crd_ts_source
    import chirp_rate_pkg::*;
#(
    parameter int      TS_W   = 32,
    parameter ts_src_e TS_SRC = TS_EXTERNAL
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [TS_W-1:0] ts_ext_i,
    output logic [TS_W-1:0] ts_o
);

    generate
        if (TS_SRC == TS_INTERNAL) begin : g_internal
            logic [TS_W-1:0] tick_q;

            // Purpose: free-running tick counter, cleared by reset.
            always_ff @(posedge clk) begin
                if (!rst_n) tick_q <= '0;
                else        tick_q <= tick_q + 1'b1;
            end

            assign ts_o = tick_q;
        end else begin : g_external
            assign ts_o = ts_ext_i;
        end
    endgenerate

endmodule

// File: rtl/crd_gap_judge.sv
// Module: crd_gap_judge
// Keeps the tick value of the last event and works out the gap to the
// current tick value (modulo 2^TS_W). Flags the gap as short when it is
// at most GAP_LIMIT.
// Assumes: ts_i is valid in the cycle in which evt_i is high.
module crd_gap_judge #(
    parameter int          TS_W      = 32,
    parameter int unsigned GAP_LIMIT = 12582912
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            evt_i,
    input  logic [TS_W-1:0] ts_i,
    output logic            near_o,
    output logic [TS_W-1:0] prev_o
);

    localparam logic [TS_W-1:0] LIMIT = TS_W'(GAP_LIMIT);

    logic [TS_W-1:0] prev_q;
    logic [TS_W-1:0] gap;

    // Purpose: gap since the last event, wrapping naturally at 2^TS_W.
    always_comb begin
        gap    = ts_i - prev_q;
        near_o = (gap <= LIMIT);
    end

    // Purpose: store the tick value of every event.
    always_ff @(posedge clk) begin
        if (!rst_n)     prev_q <= '0;
        else if (evt_i) prev_q <= ts_i;
    end

    assign prev_o = prev_q;

endmodule

// File: rtl/crd_burst_counter.sv
// Module: crd_burst_counter
// Counts close events with a saturating counter and restarts it at 1 on a
// long gap. Registers a one-cycle hit when the new count exceeds HIT_ABOVE.
// Assumes: HIT_ABOVE is below the counter maximum 2^CNT_W - 1.
module crd_burst_counter #(
    parameter int CNT_W     = 4,
    parameter int HIT_ABOVE = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             evt_i,
    input  logic             near_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             hit_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
    localparam logic [CNT_W-1:0] THRESH  = CNT_W'(HIT_ABOVE);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_inc;
    logic [CNT_W-1:0] cnt_d;
    logic             hit_q;
    logic             hit_d;

    // Purpose: next count and hit decision for the current event.
    always_comb begin
        cnt_inc = (cnt_q == CNT_MAX) ? CNT_MAX : cnt_q + CNT_ONE;
        cnt_d   = near_i ? cnt_inc : CNT_ONE;
        hit_d   = evt_i && near_i && (cnt_inc > THRESH);
    end

    // Purpose: count update on events only.
    always_ff @(posedge clk) begin
        if (!rst_n)     cnt_q <= '0;
        else if (evt_i) cnt_q <= cnt_d;
    end

    // Purpose: register the single-cycle hit flag.
    always_ff @(posedge clk) begin
        if (!rst_n) hit_q <= 1'b0;
        else        hit_q <= hit_d;
    end

    assign cnt_o = cnt_q;
    assign hit_o = hit_q;

endmodule

// File: rtl/chirp_rate_detector.sv
// Module: chirp_rate_detector (top)
// Declares a chirp detection when pulse events follow each other within
// GAP_LIMIT ticks often enough. Tick source is chosen by TS_SRC.
// Assumes: evt_i is a one-cycle strobe per classified pulse.
module chirp_rate_detector
    import chirp_rate_pkg::*;
#(
    parameter int          TS_W      = 32,
    parameter int unsigned GAP_LIMIT = GAP_LIMIT_DEF,
    parameter int          CNT_W     = 4,
    parameter int          HIT_ABOVE = 8,
    parameter ts_src_e     TS_SRC    = TS_EXTERNAL
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        evt_i,
    input  logic [31:0] ts_ext_i,
    output logic        hit_o
);

    logic [TS_W-1:0]  ts_now;
    logic [TS_W-1:0]  prev_ts;
    logic             near;
    logic [CNT_W-1:0] run_cnt;

    crd_ts_source #(.TS_W(TS_W), .TS_SRC(TS_SRC)) u_ts (
        .clk      (clk),
        .rst_n    (rst_n),
        .ts_ext_i (TS_W'(ts_ext_i)),
        .ts_o     (ts_now)
    );

    crd_gap_judge #(.TS_W(TS_W), .GAP_LIMIT(GAP_LIMIT)) u_gap (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt_i  (evt_i),
        .ts_i   (ts_now),
        .near_o (near),
        .prev_o (prev_ts)
    );

    crd_burst_counter #(.CNT_W(CNT_W), .HIT_ABOVE(HIT_ABOVE)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt_i  (evt_i),
        .near_i (near),
        .cnt_o  (run_cnt),
        .hit_o  (hit_o)
    );

endmodule

// File: rtl/chirp_rate_detector_chk.sv
// Module: chirp_rate_detector_chk
// Temporal checks on the detector, attached to every instance by bind.
// Assumes: connected to the top-level ports and internal state nets.
module chirp_rate_detector_chk #(
    parameter int TS_W  = 32,
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             evt_i,
    input logic             near,
    input logic [TS_W-1:0]  ts_now,
    input logic [TS_W-1:0]  prev_ts,
    input logic [CNT_W-1:0] run_cnt,
    input logic             hit_o
);

    // R7: a hit only follows a sampled event
    a_r7_hit_after_event: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |-> $past(evt_i));

    // R9: no event leaves count and stored tick untouched
    a_r9_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !evt_i |=> ($stable(run_cnt) && $stable(prev_ts)));

    // R8: every event stores its tick value
    a_r8_prev_tracks: assert property (@(posedge clk) disable iff (!rst_n)
        evt_i |=> (prev_ts == $past(ts_now)));

    // R4: long gap restarts at one with no hit
    a_r4_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i && !near) |=> (run_cnt == CNT_W'(1) && !hit_o));

    // R5: count never wraps to zero after an event
    a_r5_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        evt_i |=> (run_cnt != '0));

endmodule

bind chirp_rate_detector chirp_rate_detector_chk #(.TS_W(TS_W), .CNT_W(CNT_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .evt_i   (evt_i),
    .near    (near),
    .ts_now  (ts_now),
    .prev_ts (prev_ts),
    .run_cnt (run_cnt),
    .hit_o   (hit_o)
);

// File: tb/chirp_rate_detector_tb_top.sv
module chirp_rate_detector_tb_top;

    localparam logic [31:0] LIM = 32'd12582912;

    // Table of {gap to previous event, expected hit}, walked from reset.
    localparam logic [32:0] VEC [0:18] = '{
        {32'd1000, 1'b0}, {32'd1000, 1'b0}, {32'd1000, 1'b0}, {32'd1000, 1'b0},
        {32'd1000, 1'b0}, {32'd1000, 1'b0}, {32'd1000, 1'b0}, {32'd1000, 1'b0},
        {32'd1000, 1'b1}, {32'd1000, 1'b1},
        {LIM + 32'd1, 1'b0},
        {LIM, 1'b0}, {LIM, 1'b0}, {LIM, 1'b0}, {LIM, 1'b0},
        {LIM, 1'b0}, {LIM, 1'b0}, {LIM, 1'b0}, {LIM, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        evt_i = 1'b0;
    logic [31:0] ts_ext_i = '0;
    logic        hit_o;
    logic [31:0] ts_acc;
    int          n_run = 0;
    int          n_fail = 0;

    always #10 clk = ~clk;

    chirp_rate_detector dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt_i    (evt_i),
        .ts_ext_i (ts_ext_i),
        .hit_o    (hit_o)
    );

    task automatic check(input logic act, input logic exp, input string req);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: hit_o=%0b expected %0b", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        evt_i = 1'b0;
        repeat (3) @(negedge clk);
        rst_n  = 1'b1;
        ts_acc = '0;
    endtask

    // One event at tick value t; hit_o checked after the sampling edge,
    // then checked low one cycle later.
    task automatic fire(input logic [31:0] t, input logic exp, input string req);
        ts_ext_i = t;
        evt_i    = 1'b1;
        @(negedge clk);
        evt_i = 1'b0;
        check(hit_o, exp, req);
        @(negedge clk);
        check(hit_o, 1'b0, "R7 single-cycle pulse");
    endtask

    initial begin
        #(20 * 150000);
        n_fail++;
        $display("FAIL watchdog: run did not finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        do_reset();
        check(hit_o, 1'b0, "R6 reset value");

        // Table walk: R2 close gaps, R3 ninth event hits, R4 restart, R2 at limit
        foreach (VEC[i]) begin
            ts_acc = ts_acc + VEC[i][32:1];
            fire(ts_acc, VEC[i][0], "R2/R3/R4 table");
        end

        // R9: tick input moves without events, next close event still hits
        ts_ext_i = 32'hDEAD_BEEF;
        repeat (5) @(negedge clk);
        check(hit_o, 1'b0, "R9 idle no hit");
        ts_acc = ts_acc + 32'd5;
        fire(ts_acc, 1'b1, "R9 state held while idle");

        // R5: long run saturates and keeps hitting
        for (int k = 0; k < 10; k++) begin
            ts_acc = ts_acc + 32'd1;
            fire(ts_acc, 1'b1, "R5 saturated hit");
        end
        // Restart while saturated: R4 then count must be at 1
        ts_acc = ts_acc + LIM + 32'd1;
        fire(ts_acc, 1'b0, "R4 restart from saturation");
        for (int k = 0; k < 7; k++) begin
            ts_acc = ts_acc + 32'd1;
            fire(ts_acc, 1'b0, "R4 count restarted at 1");
        end
        ts_acc = ts_acc + 32'd1;
        fire(ts_acc, 1'b1, "R3 hit after restart");

        // R6: reset clears count; first event measured against zero
        do_reset();
        fire(LIM, 1'b0, "R6 first event vs zero");
        for (int k = 1; k < 8; k++) fire(LIM + k, 1'b0, "R6 count from 1");
        fire(LIM + 8, 1'b1, "R6 ninth close event");

        // R1: wrap of the tick value; R8 stored value replaced on a long gap
        do_reset();
        fire(32'hFFFF_FF00, 1'b0, "R1 long gap from zero");
        fire(32'h0000_0100, 1'b0, "R1 wrapped gap is short");
        for (int k = 0; k < 6; k++) fire(32'h0000_0200 + k, 1'b0, "R1 count up");
        fire(32'h0000_0300, 1'b1, "R1 ninth after wrap");
        // R8: long gap event stores its tick; next close gap measured from it
        fire(32'h4000_0000, 1'b0, "R8 long gap");
        fire(32'h4000_0000 + LIM, 1'b0, "R8 measured from stored tick");

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule